// File: doc/BRIEF.md
# Asynchronous DRAM Strobe Decoder

This block sits on the device side of a memory emulator. It watches the asynchronous row strobe, column strobe, output enable and the two byte write enables of a 16-bit dynamic memory bus. It turns those strobes into operations on a small word array that runs on a fast system clock. Every strobe, the multiplexed address and the input data pass through a two-stage synchronizer. The control unit then works on edges of the synchronized levels.

A row-strobe fall latches the row. Each later column-strobe fall latches a column and starts one of two accesses. It is a read when both write enables are high, and an early write when either one is low. A write enable that falls during a read access turns it into a read-modify-write. If the column strobe is already low when the row strobe falls, the access is a refresh. Read data stays on the bus after the column strobe rises, in the extended-data-out style, until one of the defined turn-off events. The bus is presented as a data vector plus one output-enable flag, so the pad ring can build the tri-state driver.

All strobe inputs are active low. The array holds 2^(2*ADDR_W) words. Row bits form the upper half of the word index and column bits the lower half: index = row * 2^ADDR_W + col.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, and whenever the row strobe is high with no read data held, dqOe is 0.
- R2: A row-strobe fall with the column strobe high latches addr as the row. A later column-strobe fall latches addr as the column. Both access word row * 2^ADDR_W + col.
- R3: A row-strobe fall while the column strobe is low is a refresh. The address is ignored, dqOe stays 0, no word of the array changes, and an internal refresh row counter advances by one.
- R4: A column-strobe fall with both write enables high is a read. The whole 16-bit word appears on dqOut, and dqOe equals the inverse of oeN while the column strobe is low.
- R5: A write changes only the lanes whose enable is low. lweN covers bits 7:0 and uweN covers bits 15:8.
- R6: A write enable that is low at the column-strobe fall makes an early write, and dqOe stays 0 for that whole access even when oeN is low.
- R7: A write enable that falls while the column strobe is low in a read access writes dqIn into the enabled lanes of the same word. The old word was driven first.
- R8: After a read, the data stays driven with the column strobe high, as long as the row strobe is low and oeN is low.
- R9: Held data turns off when the row and column strobes are both high.
- R10: A rise of oeN while the column strobe is high turns held data off. It stays off when oeN returns low, until the next read.
- R11: A write enable that pulses low while the column strobe is high turns held data off and writes nothing.
- R12: Further column-strobe falls while the row strobe stays low reuse the latched row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast system clock that oversamples the strobes |
| rst_n | input | 1 | active-low synchronous reset |
| rasN | input | 1 | row strobe, active low |
| casN | input | 1 | column strobe, active low |
| oeN | input | 1 | output enable, active low |
| lweN | input | 1 | lower byte write enable (bits 7:0), active low |
| uweN | input | 1 | upper byte write enable (bits 15:8), active low |
| addr | input | ADDR_W | multiplexed row/column address |
| dqIn | input | 16 | write data from the bus |
| dqOut | output | 16 | read data toward the bus |
| dqOe | output | 1 | drive enable for dqOut |

## Verification
A strobe edge reaches the synchronized level after two clock edges. Its registered effect lands on the third edge: a latched address, an array write, the read word on dqOut, or dqOe rising after a read or falling after a turn-off event. A change of oeN alone moves dqOe after two edges. The bench changes inputs only on falling clock edges and then waits five rising edges before it samples at a falling edge, so each result is already settled. Address and write data pass through the same two-stage pipeline as the strobes, so they are held steady across the same window.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ACTIVE  = 2'd1,
    ST_REFRESH = 2'd2
  } rowState_t;

  // strobes from control to datapath, all single-cycle pulses
  typedef struct packed {
    logic latchRow;
    logic latchCol;
    logic doRefresh;
    logic rdLoad;
    logic wrLo;
    logic wrHi;
    logic useLatchedCol;
  } dpCtrl_t;
endpackage

// File: rtl/dsd_sync.sv
module dsd_sync #(
  parameter int   WIDTH   = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[g] <= {WIDTH{RST_VAL}};
      else if (g == 0) stg[g] <= d;
      else stg[g] <= stg[(g > 0) ? g - 1 : 0];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsd_ctrl.sv
module dsd_ctrl
  import dsd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    rasS,
  input  logic    casS,
  input  logic    oeS,
  input  logic    lweS,
  input  logic    uweS,
  output dpCtrl_t ctl,
  output logic    driveEn
);
  logic rasP, casP, oeP, lweP, uweP;
  logic rasFall, rasRise, casFall, oeRise, lweFall, uweFall;
  logic holdValid, rdCycle, rmwWrite;
  rowState_t state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rasP <= 1'b1; casP <= 1'b1; oeP <= 1'b1; lweP <= 1'b1; uweP <= 1'b1;
    end else begin
      rasP <= rasS; casP <= casS; oeP <= oeS; lweP <= lweS; uweP <= uweS;
    end
  end

  assign rasFall = rasP & ~rasS;
  assign rasRise = ~rasP & rasS;
  assign casFall = casP & ~casS;
  assign oeRise  = ~oeP & oeS;
  assign lweFall = lweP & ~lweS;
  assign uweFall = uweP & ~uweS;

  assign rmwWrite = (state == ST_ACTIVE) && rdCycle && !casS && !casFall
                    && (lweFall || uweFall);

  always_comb begin
    ctl = '0;
    if (rasFall) begin
      if (!casS) ctl.doRefresh = 1'b1;
      else       ctl.latchRow  = 1'b1;
    end
    if (state == ST_ACTIVE && casFall) begin
      ctl.latchCol = 1'b1;
      if (!lweS || !uweS) begin
        ctl.wrLo = !lweS;
        ctl.wrHi = !uweS;
      end else begin
        ctl.rdLoad = 1'b1;
      end
    end
    if (rmwWrite) begin
      ctl.wrLo          = lweFall;
      ctl.wrHi          = uweFall;
      ctl.useLatchedCol = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      holdValid <= 1'b0;
      rdCycle   <= 1'b0;
    end else begin
      if (rasRise)      state <= ST_IDLE;
      else if (rasFall) state <= casS ? ST_ACTIVE : ST_REFRESH;

      if (ctl.rdLoad)        rdCycle <= 1'b1;
      else if (ctl.latchCol || rasRise) rdCycle <= 1'b0;

      if (ctl.rdLoad)                                   holdValid <= 1'b1;
      else if (ctl.latchCol)                            holdValid <= 1'b0;
      else if (rasS && casS)                            holdValid <= 1'b0;
      else if (casS && (oeRise || lweFall || uweFall))  holdValid <= 1'b0;
    end
  end

  assign driveEn = holdValid && !oeS;

  // R6
  early_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.latchCol && !ctl.rdLoad) |=> !driveEn);
  // R9
  standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rasS && casS) |=> !driveEn);
  // R10
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (casS && oeRise) |=> !driveEn);
  // R7
  rmw_cas_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.useLatchedCol |-> (!casS && state == ST_ACTIVE));
endmodule

// File: rtl/dsd_datapath.sv
module dsd_datapath
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] addrS,
  input  logic [DATA_W-1:0] dqS,
  output logic [DATA_W-1:0] rdData
);
  localparam int IDX_W = 2 * ADDR_W;
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] rowReg, colReg, refCnt;
  logic [IDX_W-1:0]  wrIdx, rdIdx;

  assign rdIdx = {rowReg, addrS};
  assign wrIdx = {rowReg, ctl.useLatchedCol ? colReg : addrS};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rowReg <= '0;
      colReg <= '0;
      refCnt <= '0;
      rdData <= '0;
    end else begin
      if (ctl.latchRow)  rowReg <= addrS;
      if (ctl.latchCol)  colReg <= addrS;
      if (ctl.doRefresh) refCnt <= refCnt + 1'b1;
      if (ctl.rdLoad)    rdData <= mem[rdIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.wrLo) mem[wrIdx][7:0]  <= dqS[7:0];
    if (ctl.wrHi) mem[wrIdx][15:8] <= dqS[15:8];
  end

  // lane isolation checker state
  logic             chkArm;
  logic [IDX_W-1:0] chkIdx;
  logic [7:0]       chkHi;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkArm <= 1'b0;
      chkIdx <= '0;
      chkHi  <= '0;
    end else begin
      chkArm <= ctl.wrLo && !ctl.wrHi;
      chkIdx <= wrIdx;
      chkHi  <= mem[wrIdx][15:8];
    end
  end

  // R5
  lane_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chkArm |-> mem[chkIdx][15:8] == chkHi);
  // R3
  refresh_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doRefresh |=> refCnt == ADDR_W'($past(refCnt) + 1'b1));
  // R3
  refresh_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.doRefresh |-> !(ctl.wrLo || ctl.wrHi || ctl.latchRow || ctl.rdLoad));
endmodule

// File: rtl/dram_strobe_decoder.sv
module dram_strobe_decoder
  import dsd_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rasN,
  input  logic              casN,
  input  logic              oeN,
  input  logic              lweN,
  input  logic              uweN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dqIn,
  output logic [15:0]       dqOut,
  output logic              dqOe
);
  localparam int BUS_W = ADDR_W + DATA_W;

  logic [4:0]        strobeS;
  logic [BUS_W-1:0]  busS;
  dpCtrl_t           ctl;

  dsd_sync #(.WIDTH(5), .STAGES(2), .RST_VAL(1'b1)) i_strobeSync (
    .clk(clk), .rst_n(rst_n),
    .d({rasN, casN, oeN, lweN, uweN}), .q(strobeS));

  dsd_sync #(.WIDTH(BUS_W), .STAGES(2), .RST_VAL(1'b0)) i_busSync (
    .clk(clk), .rst_n(rst_n),
    .d({addr, dqIn}), .q(busS));

  dsd_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rasS(strobeS[4]), .casS(strobeS[3]), .oeS(strobeS[2]),
    .lweS(strobeS[1]), .uweS(strobeS[0]),
    .ctl(ctl), .driveEn(dqOe));

  dsd_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .addrS(busS[BUS_W-1:DATA_W]), .dqS(busS[DATA_W-1:0]),
    .rdData(dqOut));
endmodule

// File: tb/test_dram_strobe_decoder.sv
module test_dram_strobe_decoder;
  localparam int AW    = 3;
  localparam int NCOL  = 1 << AW;
  localparam int DEPTH = NCOL * NCOL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rasN = 1, casN = 1, oeN = 1, lweN = 1, uweN = 1;
  logic [AW-1:0] addr = '0;
  logic [15:0] dqIn = '0, dqOut;
  logic dqOe;
  logic [15:0] refMem [DEPTH];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_strobe_decoder #(.ADDR_W(AW)) i_dram_strobe_decoder (
    .clk(clk), .rst_n(rst_n), .rasN(rasN), .casN(casN), .oeN(oeN),
    .lweN(lweN), .uweN(uweN), .addr(addr), .dqIn(dqIn),
    .dqOut(dqOut), .dqOe(dqOe));

  function automatic logic [15:0] pat(int i, int salt);
    return 16'((i * 16'h1357 + salt * 16'h0F31) ^ 16'hA5C3);
  endfunction

  task automatic step();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic openRow(int r);
    addr = AW'(r); step();
    rasN = 0; step();
  endtask

  task automatic closeRow();
    rasN = 1; casN = 1; oeN = 1; lweN = 1; uweN = 1; step();
    check(dqOe == 0, "R9/R1 standby", dqOe, 0);
  endtask

  task automatic earlyWrite(int r, int c, bit lo, bit hi, logic [15:0] d);
    int idx = r * NCOL + c;
    addr = AW'(c); dqIn = d; oeN = 0; lweN = !lo; uweN = !hi; step();
    casN = 0; step();
    check(dqOe == 0, "R6 early write keeps bus off", dqOe, 0);
    casN = 1; lweN = 1; uweN = 1; step();
    if (lo) refMem[idx][7:0]  = d[7:0];
    if (hi) refMem[idx][15:8] = d[15:8];
  endtask

  task automatic pageRead(int r, int c, string req);
    int idx = r * NCOL + c;
    addr = AW'(c); oeN = 0; step();
    casN = 0; step();
    check(dqOe == 1 && dqOut == refMem[idx], req, {dqOe, 15'd0, dqOut}, {1'b1, 15'd0, refMem[idx]});
    casN = 1; step();
    check(dqOe == 1 && dqOut == refMem[idx], "R8 data held after column strobe rises",
          {dqOe, 15'd0, dqOut}, {1'b1, 15'd0, refMem[idx]});
  endtask

  task automatic cbrRefresh(int junk);
    casN = 0; step();
    addr = AW'(junk); oeN = 0; rasN = 0; step();
    check(dqOe == 0, "R3 refresh does not drive", dqOe, 0);
    rasN = 1; step();
    casN = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; step();
    check(dqOe == 0, "R1 reset state off", dqOe, 0);

    // R2 R5 R6: word writes across the whole array, page mode per row
    for (int r = 0; r < NCOL; r++) begin
      openRow(r);
      for (int c = 0; c < NCOL; c++) earlyWrite(r, c, 1, 1, pat(r * NCOL + c, 1));
      closeRow();
    end
    // R2 R4 R12: read back, columns reuse the latched row
    for (int r = 0; r < NCOL; r++) begin
      openRow(r);
      for (int c = 0; c < NCOL; c++) pageRead(r, c, "R12/R2/R4 page read");
      closeRow();
    end
    // R5: lane sweep, lower lane on even words, upper on odd words
    for (int r = 0; r < NCOL; r++) begin
      openRow(r);
      for (int c = 0; c < NCOL; c++)
        earlyWrite(r, c, (c % 2) == 0, (c % 2) == 1, pat(r * NCOL + c, 7));
      closeRow();
    end
    for (int r = 0; r < NCOL; r++) begin
      openRow(r);
      for (int c = 0; c < NCOL; c++) pageRead(r, c, "R5 byte lane isolation");
      closeRow();
    end

    // R3: refresh with junk address changes nothing
    for (int k = 0; k < 3; k++) cbrRefresh(k + 5);
    openRow(2);
    for (int c = 0; c < NCOL; c++) pageRead(2, c, "R3 array unchanged after refresh");
    closeRow();

    // R4: output enable toggling while column strobe low
    openRow(1);
    addr = 3; oeN = 0; step(); casN = 0; step();
    oeN = 1; step();
    check(dqOe == 0, "R4 oeN high disables drive", dqOe, 0);
    oeN = 0; step();
    check(dqOe == 1 && dqOut == refMem[1*NCOL+3], "R4 oeN low re-enables", dqOut, refMem[1*NCOL+3]);
    casN = 1; step();

    // R10: oeN rise with column strobe high ends hold for good
    oeN = 1; step();
    check(dqOe == 0, "R10 oeN rise turns off", dqOe, 0);
    oeN = 0; step();
    check(dqOe == 0, "R10 stays off after oeN low", dqOe, 0);

    // R11: write enable pulse with column strobe high
    pageRead(1, 4, "R4 read before pulse");
    lweN = 0; uweN = 0; dqIn = 16'hDEAD; step();
    check(dqOe == 0, "R11 write enable pulse turns off", dqOe, 0);
    lweN = 1; uweN = 1; step();
    pageRead(1, 4, "R11 pulse wrote nothing");
    closeRow();

    // R7: read-modify-write, full word then lower lane only
    for (int k = 0; k < 2; k++) begin
      int c = 5 + k;
      int idx = 6 * NCOL + c;
      logic [15:0] nd = pat(idx, 11);
      openRow(6);
      addr = AW'(c); oeN = 0; step(); casN = 0; step();
      check(dqOe == 1 && dqOut == refMem[idx], "R7 old data first", dqOut, refMem[idx]);
      oeN = 1; step();
      dqIn = nd; lweN = 0; uweN = (k == 1); step();
      lweN = 1; uweN = 1; casN = 1; step();
      refMem[idx][7:0] = nd[7:0];
      if (k == 0) refMem[idx][15:8] = nd[15:8];
      pageRead(6, c, "R7 new data written");
      closeRow();
    end

    // R9: row and column strobe both high end the hold
    openRow(3);
    pageRead(3, 2, "R4 read");
    rasN = 1; step();
    check(dqOe == 0, "R9 both strobes high turn off", dqOe, 0);
    closeRow();

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog run did not finish actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule